// File: doc/BRIEF.md
# Local Interrupt Priority Arbiter

This block holds the pending and active interrupt state of one processor core. Each of the 2^VEC_W vectors has a pending bit, an active (in-service) bit and a trigger-kind bit. Priority rises with vector number. The upper four bits of a vector form its priority class. A programmable task threshold, together with the class of the highest active vector, gives a current core priority. Pending work must beat that priority before the interrupt line goes up.

The core claims the best pending vector with an acknowledge strobe and retires the best active vector with an end-of-service strobe. Requests arrive as a strobe with a vector number and a level/edge flag. A control word holds the enable bit and the value returned when an acknowledge finds nothing deliverable. Both the threshold and the control word are loaded from a shared write-data bus.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After reset the interrupt line is low, the priority output is 0, the threshold is 0 and the control word is 0x0FF, so the unit is disabled (bit 8 clear) and its fallback vector is 0xFF.
- R2: A request strobe sets the pending bit of its vector. It also records the trigger kind, 1 for level and 0 for edge, and a later request for the same vector overwrites that record. On a delivering acknowledge, `ack_level` returns the recorded kind of the granted vector; after a fallback it returns 0.
- R3: An acknowledge considers the highest-numbered pending vector.
- R4: The priority output equals the threshold when the threshold's class (bits 7:4) is at least the class of the highest active vector, and equals that class shifted left by 4 otherwise. An empty active set counts as class 0.
- R5: The interrupt line rises when all three of these hold: the enable bit is set, some vector is pending, and either the priority output is 0 or the class of the highest pending vector is strictly above the priority class. It is registered and follows the state one cycle after the state changes.
- R6: If an acknowledge arrives while the threshold is nonzero and the best pending vector is less than or equal to the full threshold value, it returns the low byte of the control word and changes no state.
- R7: An acknowledge with nothing pending returns the low byte of the control word and changes no state.
- R8: Any other acknowledge returns the best pending vector, clears its pending bit and sets its active bit.
- R9: An end-of-service strobe clears the highest-numbered active bit and has no effect when the active set is empty.
- R10: A control-word write keeps only bits 8:0 of the write data. Bit 8 is the enable bit, and clearing it holds the interrupt line low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_vector | input | VEC_W | Requested vector |
| req_level | input | 1 | 1 = level-triggered request, 0 = edge |
| ack | input | 1 | Acknowledge strobe from the core |
| eoi | input | 1 | End-of-service strobe |
| tpr_we | input | 1 | Threshold write enable |
| ctl_we | input | 1 | Control-word write enable |
| wr_data | input | DATA_W | Write data for the threshold (low VEC_W bits) or the control word (low VEC_W+1 bits) |
| irq | output | 1 | Interrupt line to the core |
| ack_vector | output | VEC_W | Vector returned by the last acknowledge |
| ack_level | output | 1 | Trigger kind of the vector granted by the last acknowledge |
| ppr | output | VEC_W | Current core priority |

## Verification
The bench builds the block with its defaults, VEC_W = 8 and DATA_W = 32. This gives the full 256-vector space, so both end vectors 0x00 and 0xFF are reachable, along with the 16 priority classes that the threshold and class comparisons act on. The 32-bit write bus lets a control-word write carry bits above bit 8, which shows that only the low nine bits are kept.

// File: rtl/irq_prio_arbiter.sv
`timescale 1ns/1ps
module irq_prio_arbiter #(
  parameter int VEC_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VEC_W-1:0]  req_vector,
  input  logic              req_level,
  input  logic              ack,
  input  logic              eoi,
  input  logic              tpr_we,
  input  logic              ctl_we,
  input  logic [DATA_W-1:0] wr_data,
  output logic              irq,
  output logic [VEC_W-1:0]  ack_vector,
  output logic              ack_level,
  output logic [VEC_W-1:0]  ppr
);
  localparam int NVEC = 1 << VEC_W;
  localparam int CLS  = VEC_W - 4;
  localparam int CW   = VEC_W + 1;

  logic [NVEC-1:0]  irr_q, isr_q, tmr_q, irr_n, isr_n, tmr_n;
  logic [VEC_W-1:0] tpr_q;
  logic [CW-1:0]    ctl_q;
  logic             irq_q;
  logic [VEC_W-1:0] ackv_q;
  logic             ackl_q;

  function automatic logic [VEC_W:0] top_bit(input logic [NVEC-1:0] v);
    top_bit = '0;
    for (int i = 0; i < NVEC; i++)
      if (v[i]) top_bit = {1'b1, VEC_W'(i)};
  endfunction

  logic             irr_any, isr_any;
  logic [VEC_W-1:0] irr_top, isr_top;
  assign {irr_any, irr_top} = top_bit(irr_q);
  assign {isr_any, isr_top} = top_bit(isr_q);

  logic [3:0] isr_cls, tpr_cls;
  assign isr_cls = isr_any ? isr_top[VEC_W-1:CLS] : 4'd0;
  assign tpr_cls = tpr_q[VEC_W-1:CLS];
  assign ppr     = (tpr_cls >= isr_cls) ? tpr_q : {isr_cls, {CLS{1'b0}}};

  logic irq_next, ack_spur, ack_take;
  assign irq_next = ctl_q[VEC_W] && irr_any &&
                    (ppr == '0 || irr_top[VEC_W-1:CLS] > ppr[VEC_W-1:CLS]);
  assign ack_spur = !irr_any || (tpr_q != '0 && irr_top <= tpr_q);
  assign ack_take = ack && !ack_spur;

  always_comb begin
    irr_n = irr_q;
    isr_n = isr_q;
    tmr_n = tmr_q;
    if (ack_take) begin
      irr_n[irr_top] = 1'b0;
      isr_n[irr_top] = 1'b1;
    end
    if (eoi && isr_any) isr_n[isr_top] = 1'b0;
    if (req_valid) begin
      irr_n[req_vector] = 1'b1;
      tmr_n[req_vector] = req_level;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q  <= '0;
      isr_q  <= '0;
      tmr_q  <= '0;
      tpr_q  <= '0;
      ctl_q  <= {1'b0, {VEC_W{1'b1}}};
      irq_q  <= 1'b0;
      ackv_q <= '0;
      ackl_q <= 1'b0;
    end else begin
      irr_q <= irr_n;
      isr_q <= isr_n;
      tmr_q <= tmr_n;
      irq_q <= irq_next;
      if (tpr_we) tpr_q <= wr_data[VEC_W-1:0];
      if (ctl_we) ctl_q <= wr_data[CW-1:0];
      if (ack) begin
        ackv_q <= ack_spur ? ctl_q[VEC_W-1:0] : irr_top;
        ackl_q <= ack_take & tmr_q[irr_top];
      end
    end
  end

  assign irq        = irq_q;
  assign ack_vector = ackv_q;
  assign ack_level  = ackl_q;

  // R10
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q[VEC_W] |=> !irq_q);

  // R2
  req_sets_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> irr_q[$past(req_vector)]);

  // R6
  spur_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && ack_spur && !req_valid && !eoi) |=> ($stable(irr_q) && $stable(isr_q)));

  // R9
  eoi_one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && isr_any && !ack) |=> ($countones(isr_q) == $countones($past(isr_q)) - 1));

  // R4
  ppr_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ppr >= tpr_q);
endmodule

// File: tb/irq_prio_arbiter_tb.sv
`timescale 1ns/1ps
module irq_prio_arbiter_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_level = 0, ack = 0, eoi = 0, tpr_we = 0, ctl_we = 0;
  logic [7:0]  req_vector = '0;
  logic [31:0] wr_data = '0;
  logic irq, ack_level;
  logic [7:0] ack_vector, ppr;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_prio_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vector(req_vector),
    .req_level(req_level), .ack(ack), .eoi(eoi), .tpr_we(tpr_we), .ctl_we(ctl_we),
    .wr_data(wr_data), .irq(irq), .ack_vector(ack_vector), .ack_level(ack_level),
    .ppr(ppr));

  // op: 0 request (data[8] = level), 1 ack, 2 end-of-service, 3 threshold, 4 control
  function automatic logic [39:0] mk(input int op, input int data, input int ev,
      input int el, input int ca, input int ei, input int ep, input int rq);
    mk = {3'(op), 10'(data), 8'(ev), 1'(el), 1'(ca), 1'(ei), 8'(ep), 8'(rq)};
  endfunction

  localparam int NENT = 35;
  localparam logic [39:0] TBL [NENT] = '{
    mk(0, 'h031, 0,    0, 0, 0, 'h00, 5),   // R5 disabled, no line
    mk(4, 'h10F, 0,    0, 0, 1, 'h00, 5),   // R5 enable raises line
    mk(0, 'h152, 0,    0, 0, 1, 'h00, 2),   // R2 level request
    mk(1, 0,     'h52, 1, 1, 0, 'h50, 4),   // R4 active class 5
    mk(0, 'h061, 0,    0, 0, 1, 'h50, 5),   // R5 class 6 beats 5
    mk(1, 0,     'h61, 0, 1, 0, 'h60, 8),   // R8
    mk(2, 0,     0,    0, 0, 0, 'h50, 9),   // R9
    mk(3, 'h070, 0,    0, 0, 0, 'h70, 4),   // R4 threshold wins
    mk(0, 'h075, 0,    0, 0, 0, 'h70, 5),   // R5 equal class blocked
    mk(1, 0,     'h75, 0, 1, 0, 'h70, 6),   // R6 above full threshold delivered
    mk(0, 'h06F, 0,    0, 0, 0, 'h70, 5),
    mk(1, 0,     'h0F, 0, 1, 0, 'h70, 6),   // R6 fallback
    mk(2, 0,     0,    0, 0, 0, 'h70, 9),   // R9
    mk(3, 'h000, 0,    0, 0, 1, 'h50, 4),   // R4
    mk(2, 0,     0,    0, 0, 1, 'h00, 9),   // R9
    mk(1, 0,     'h6F, 0, 1, 0, 'h60, 3),   // R3 pending kept after fallback
    mk(2, 0,     0,    0, 0, 1, 'h00, 9),
    mk(1, 0,     'h31, 0, 1, 0, 'h30, 3),   // R3
    mk(2, 0,     0,    0, 0, 0, 'h00, 9),
    mk(2, 0,     0,    0, 0, 0, 'h00, 9),   // R9 empty
    mk(1, 0,     'h0F, 0, 1, 0, 'h00, 7),   // R7
    mk(4, 'h3AB, 0,    0, 0, 0, 'h00, 10),  // R10 upper bits dropped
    mk(1, 0,     'hAB, 0, 1, 0, 'h00, 10),  // R10 new fallback byte
    mk(0, 'h1F0, 0,    0, 0, 1, 'h00, 2),
    mk(0, 'h0F0, 0,    0, 0, 1, 'h00, 2),
    mk(1, 0,     'hF0, 0, 1, 0, 'hF0, 2),   // R2 kind overwritten to edge
    mk(2, 0,     0,    0, 0, 0, 'h00, 9),
    mk(4, 'h0AB, 0,    0, 0, 0, 'h00, 10),
    mk(0, 'h090, 0,    0, 0, 0, 'h00, 10),  // R10 disabled holds line low
    mk(4, 'h1AB, 0,    0, 0, 1, 'h00, 10),
    mk(1, 0,     'h90, 0, 1, 0, 'h90, 8),
    mk(2, 0,     0,    0, 0, 0, 'h00, 9),
    mk(0, 'h000, 0,    0, 0, 1, 'h00, 5),   // R5 vector 0 with priority 0
    mk(1, 0,     'h00, 0, 1, 0, 'h00, 3),
    mk(2, 0,     0,    0, 0, 0, 'h00, 9)
  };

  task automatic chk(input string what, input int rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic do_op(input logic [2:0] op, input logic [9:0] d);
    @(negedge clk);
    case (op)
      3'd0: begin req_valid = 1; req_vector = d[7:0]; req_level = d[8]; end
      3'd1: ack = 1;
      3'd2: eoi = 1;
      3'd3: begin tpr_we = 1; wr_data = 32'(d); end
      default: begin ctl_we = 1; wr_data = 32'(d); end
    endcase
    @(negedge clk);
    req_valid = 0; ack = 0; eoi = 0; tpr_we = 0; ctl_we = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("reset irq", 1, irq, 0);          // R1
    chk("reset ppr", 1, ppr, 0);          // R1
    ack = 1; @(negedge clk); ack = 0;
    chk("reset fallback", 1, ack_vector, 'hFF);  // R1
    chk("reset ack_level", 1, ack_level, 0);      // R1
    for (int i = 0; i < NENT; i++) begin
      logic [39:0] e;
      e = TBL[i];
      do_op(e[39:37], e[36:27]);
      chk($sformatf("step %0d irq", i), e[7:0], irq, e[16]);
      chk($sformatf("step %0d ppr", i), e[7:0], ppr, e[15:8]);
      if (e[17]) begin
        chk($sformatf("step %0d ack_vector", i), e[7:0], ack_vector, e[26:19]);
        chk($sformatf("step %0d ack_level", i), e[7:0], ack_level, e[18]);
      end
    end
    // R5 registered: line follows one cycle after the request lands
    @(negedge clk); req_valid = 1; req_vector = 8'hC3; req_level = 0;
    @(negedge clk); req_valid = 0;
    chk("line lags state", 5, irq, 0);
    @(negedge clk);
    chk("line after one cycle", 5, irq, 1);
    do_op(3'd1, 0);
    chk("top vector", 3, ack_vector, 'hC3);  // R3
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule